// File: doc/BRIEF.md
# Tiny 16-bit Multi-cycle Processor Core

This block is a small multi-cycle processor for 16-bit words. It holds eight general registers, a program counter and a status value. It fetches one instruction at a time through a synchronous, word-addressed read port. The instruction set covers register and immediate addition, immediate load, PC-relative memory load, register move, unconditional jump, jump-if-negative and two traps. Immediates use sign-magnitude encoding. Every write to a register appears on a write-back port, so surrounding logic can trace results.

The core is driven by a five-state machine:
- `S_FETCH` issues a read at the PC and goes to `S_EXEC`.
- `S_EXEC` decodes the returned word and executes it. It then moves to `S_FETCH`. A PC-relative load moves to `S_LDMEM` instead, and a wait or halt trap moves to `S_PARK`.
- `S_LDMEM` writes the loaded word and returns to `S_FETCH`.
- `S_PARK` holds the core while the status is waiting or halted. When the status is waiting and a request is present, it accepts the interrupt, reads the handler table entry and goes to `S_VECTOR`.
- `S_VECTOR` loads the handler address into the PC and returns to `S_FETCH`.

A get-character trap parks the core with its PC unchanged until an interrupt is accepted. Inside the handler, the halt trap acts as the return: it acknowledges the interrupt and resumes execution one word past the parked trap.

Top module: `tiny16_core`

## Requirements
- R1: After reset all registers read as zero, the status is condition-zero, `halted` is low and the first read is issued at address 0.
- R2: Opcode 0001 writes `rd=[11:9]` with `rs1=[8:6]` plus a second operand. When `[5]=0` the second operand is register `[2:0]`. When `[5]=1` it is the 4-bit magnitude in `[3:0]`, negated when `[4]=1`.
- R3: Opcode 0010 writes `[11:9]` with the 7-bit magnitude in `[6:0]`, negated when `[7]=1`. A negative zero yields 0.
- R4: Opcode 0011 reads memory at the address of the next instruction plus the sign-extended `[8:0]`, and writes the word read to `[11:9]`.
- R5: Opcode 0110 copies register `[8:6]` into register `[11:9]`.
- R6: Opcode 0100 continues execution at the address of the next instruction plus the sign-extended `[8:0]`.
- R7: Opcode 0101 takes that same branch only when register `[11:9]` has bit 15 set; otherwise execution falls through.
- R8: A data word (opcode 1110), an unused opcode, or a trap (1111) with a code other than 0 or 1 writes nothing and advances the PC by one.
- R9: Trap code 0 outside a handler raises `halted`. From then on there are no reads, no write-backs and no accepted interrupts until reset.
- R10: Trap code 1 parks the core with no reads or write-backs. `irq_take` pulses only in the parked-waiting condition while `irq_req` is high, and a request is never accepted while instructions run.
- R11: On acceptance the core reads the table word at `TBL_BASE + irq_id` in the same cycle, sets the PC to that word and sets the status to condition-zero.
- R12: Trap code 0 inside a handler pulses `irq_ack` with `ack_id` equal to the accepted id, and execution resumes at the parked trap's address plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_rd | output | 1 | Read strobe; data returns on `mem_rdata` in the next cycle |
| mem_addr | output | 16 | Word address of the read |
| mem_rdata | input | 16 | Read data, valid the cycle after `mem_rd` |
| irq_req | input | 1 | Interrupt request level |
| irq_id | input | IDW | Id of the requested interrupt |
| irq_take | output | 1 | One-cycle pulse when a request is accepted |
| irq_ack | output | 1 | One-cycle pulse when the handler returns |
| ack_id | output | IDW | Id being acknowledged |
| halted | output | 1 | Core stopped by a halt trap |
| wb_we | output | 1 | Register write-back strobe |
| wb_reg | output | 3 | Register written |
| wb_data | output | 16 | Value written |

## Verification
The bench builds the core with `TBL_BASE` set to 0x80 and `IDW` left at 16. With these values the handler table, a handler at 0xC0, its input word at 0xF0 and the main program all fit in one 256-word model memory. This brings the full sequence within reach: wait, vector fetch, handler, acknowledge and resume. Random add, load and move sequences are checked against a bench register model. Directed words cover sign-magnitude minus zero, a backward PC-relative load, taken and untaken branches, no-op words and an interrupt held high while the program runs.

// File: rtl/tiny16_pkg.sv
package tiny16_pkg;
    localparam int XLEN = 16;
    localparam int NREG = 8;
    localparam int RIDX = $clog2(NREG);
    localparam int RELW = 9;

    localparam logic [3:0] OP_ADD  = 4'b0001;
    localparam logic [3:0] OP_LDI  = 4'b0010;
    localparam logic [3:0] OP_LDPC = 4'b0011;
    localparam logic [3:0] OP_JMP  = 4'b0100;
    localparam logic [3:0] OP_JNEG = 4'b0101;
    localparam logic [3:0] OP_MOV  = 4'b0110;

    localparam logic [7:0] TRAP_STOP = 8'd0;
    localparam logic [7:0] TRAP_GETC = 8'd1;

    typedef enum logic [2:0] {
        STAT_ZERO, STAT_POS, STAT_NEG, STAT_WAIT, STAT_HALT
    } status_e;

    typedef enum logic [2:0] {
        S_FETCH, S_EXEC, S_LDMEM, S_PARK, S_VECTOR
    } state_e;

    typedef struct packed {
        logic [3:0]      op;
        logic [RIDX-1:0] rd;
        logic [RIDX-1:0] rs1;
        logic [RIDX-1:0] rs2;
        logic            imm_mode;
        logic [XLEN-1:0] add_imm;
        logic [XLEN-1:0] ld_imm;
        logic [XLEN-1:0] rel;
        logic [7:0]      trap_code;
    } dec_t;

    function automatic logic [XLEN-1:0] sign_mag(input logic neg, input logic [6:0] mag);
        logic [XLEN-1:0] m;
        m = XLEN'(mag);
        return neg ? (~m + 1'b1) : m;
    endfunction

    function automatic status_e cond_of(input logic [XLEN-1:0] v);
        if (v == '0)      return STAT_ZERO;
        else if (v[XLEN-1]) return STAT_NEG;
        else              return STAT_POS;
    endfunction
endpackage

// File: rtl/tiny16_decode.sv
module tiny16_decode
    import tiny16_pkg::*;
(
    input  logic [XLEN-1:0] ir,
    output dec_t            dec
);
    always_comb begin
        dec.op        = ir[15:12];
        dec.rd        = ir[11:9];
        dec.rs1       = ir[8:6];
        dec.rs2       = ir[2:0];
        dec.imm_mode  = ir[5];
        dec.add_imm   = sign_mag(ir[4], {3'b000, ir[3:0]});
        dec.ld_imm    = sign_mag(ir[7], ir[6:0]);
        dec.rel       = {{(XLEN-RELW){ir[RELW-1]}}, ir[RELW-1:0]};
        dec.trap_code = ir[7:0];
    end
endmodule

// File: rtl/tiny16_regs.sv
module tiny16_regs #(
    parameter int NREG = 8,
    parameter int XLEN = 16,
    parameter int NRD  = 3,
    localparam int RIDX = $clog2(NREG)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic [RIDX-1:0]           waddr,
    input  logic [XLEN-1:0]           wdata,
    input  logic [NRD-1:0][RIDX-1:0]  raddr,
    output logic [NRD-1:0][XLEN-1:0]  rdata
);
    logic [XLEN-1:0] bank [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) bank[i] <= '0;
        end else if (we) begin
            bank[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = bank[raddr[p]];
    end
endmodule

// File: rtl/tiny16_core.sv
module tiny16_core
    import tiny16_pkg::*;
#(
    parameter logic [15:0] TBL_BASE = 16'h0100,
    parameter int          IDW      = 16
) (
    input  logic            clk,
    input  logic            rst,
    output logic            mem_rd,
    output logic [15:0]     mem_addr,
    input  logic [15:0]     mem_rdata,
    input  logic            irq_req,
    input  logic [IDW-1:0]  irq_id,
    output logic            irq_take,
    output logic            irq_ack,
    output logic [IDW-1:0]  ack_id,
    output logic            halted,
    output logic            wb_we,
    output logic [2:0]      wb_reg,
    output logic [15:0]     wb_data
);
    localparam int NRD = 3;

    state_e              state, state_n;
    status_e             status, status_n;
    logic [XLEN-1:0]     pc, pc_n, saved_pc;
    logic                in_isr;
    logic [IDW-1:0]      isr_id;
    logic [RIDX-1:0]     ld_rd, ld_rd_n;
    dec_t                d;
    logic [NRD-1:0][RIDX-1:0] raddr;
    logic [NRD-1:0][XLEN-1:0] rval;
    logic [XLEN-1:0]     pc_inc, target;

    tiny16_decode u_dec (.ir(mem_rdata), .dec(d));

    assign raddr[0] = d.rs1;
    assign raddr[1] = d.rs2;
    assign raddr[2] = d.rd;

    tiny16_regs #(.NREG(NREG), .XLEN(XLEN), .NRD(NRD)) u_regs (
        .clk(clk), .rst(rst), .we(wb_we), .waddr(wb_reg), .wdata(wb_data),
        .raddr(raddr), .rdata(rval)
    );

    assign pc_inc = pc + 1'b1;
    assign target = pc_inc + d.rel;
    assign halted = (status == STAT_HALT);
    assign ack_id = isr_id;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_FETCH;
            status   <= STAT_ZERO;
            pc       <= '0;
            saved_pc <= '0;
            in_isr   <= 1'b0;
            isr_id   <= '0;
            ld_rd    <= '0;
        end else begin
            state  <= state_n;
            status <= status_n;
            pc     <= pc_n;
            ld_rd  <= ld_rd_n;
            if (irq_take) begin
                saved_pc <= pc;
                in_isr   <= 1'b1;
                isr_id   <= irq_id;
            end else if (irq_ack) begin
                in_isr <= 1'b0;
            end
        end
    end

    // next state and outputs
    always_comb begin
        state_n  = state;
        status_n = status;
        pc_n     = pc;
        ld_rd_n  = ld_rd;
        mem_rd   = 1'b0;
        mem_addr = pc;
        irq_take = 1'b0;
        irq_ack  = 1'b0;
        wb_we    = 1'b0;
        wb_reg   = d.rd;
        wb_data  = '0;
        unique case (state)
            S_FETCH: begin
                mem_rd  = 1'b1;
                state_n = S_EXEC;
            end
            S_EXEC: begin
                pc_n    = pc_inc;
                state_n = S_FETCH;
                unique case (d.op)
                    OP_ADD: begin
                        wb_we   = 1'b1;
                        wb_data = rval[0] + (d.imm_mode ? d.add_imm : rval[1]);
                    end
                    OP_LDI: begin
                        wb_we   = 1'b1;
                        wb_data = d.ld_imm;
                    end
                    OP_MOV: begin
                        wb_we   = 1'b1;
                        wb_data = rval[0];
                    end
                    OP_LDPC: begin
                        mem_rd   = 1'b1;
                        mem_addr = target;
                        ld_rd_n  = d.rd;
                        state_n  = S_LDMEM;
                    end
                    OP_JMP:  pc_n = target;
                    OP_JNEG: pc_n = rval[2][XLEN-1] ? target : pc_inc;
                    4'b1111: begin
                        if (d.trap_code == TRAP_STOP) begin
                            if (in_isr) begin
                                irq_ack = 1'b1;
                                pc_n    = saved_pc + 1'b1;
                            end else begin
                                pc_n     = pc;
                                status_n = STAT_HALT;
                                state_n  = S_PARK;
                            end
                        end else if (d.trap_code == TRAP_GETC) begin
                            pc_n     = pc;
                            status_n = STAT_WAIT;
                            state_n  = S_PARK;
                        end
                    end
                    default: ;
                endcase
                if (wb_we) status_n = cond_of(wb_data);
            end
            S_LDMEM: begin
                wb_we    = 1'b1;
                wb_reg   = ld_rd;
                wb_data  = mem_rdata;
                status_n = cond_of(mem_rdata);
                state_n  = S_FETCH;
            end
            S_PARK: begin
                if (status == STAT_WAIT && !in_isr && irq_req) begin
                    irq_take = 1'b1;
                    mem_rd   = 1'b1;
                    mem_addr = TBL_BASE + 16'(irq_id);
                    state_n  = S_VECTOR;
                end
            end
            S_VECTOR: begin
                pc_n     = mem_rdata;
                status_n = STAT_ZERO;
                state_n  = S_FETCH;
            end
            default: state_n = S_FETCH;
        endcase
    end
endmodule

// File: rtl/tiny16_core_chk.sv
module tiny16_core_chk #(
    parameter logic [15:0] TBL_BASE = 16'h0100,
    parameter int          IDW      = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            mem_rd,
    input logic [15:0]     mem_addr,
    input logic [15:0]     mem_rdata,
    input logic            irq_req,
    input logic [IDW-1:0]  irq_id,
    input logic            irq_take,
    input logic            irq_ack,
    input logic [IDW-1:0]  ack_id,
    input logic            halted,
    input logic            wb_we,
    input logic [2:0]      wb_reg,
    input logic [15:0]     wb_data
);
    logic           pend;
    logic [IDW-1:0] seen_id;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend    <= 1'b0;
            seen_id <= '0;
        end else if (irq_take) begin
            pend    <= 1'b1;
            seen_id <= irq_id;
        end else if (irq_ack) begin
            pend <= 1'b0;
        end
    end

    assert_reset_fetch_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mem_rd && mem_addr == 16'h0000 && !halted));

    assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        halted |-> (!mem_rd && !wb_we && !irq_take));

    assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    assert_take_needs_req_R10: assert property (@(posedge clk) disable iff (rst)
        irq_take |-> (irq_req && !pend));

    assert_vector_addr_R11: assert property (@(posedge clk) disable iff (rst)
        irq_take |-> (mem_rd && mem_addr == TBL_BASE + 16'(irq_id)));

    assert_vector_fetch_R11: assert property (@(posedge clk) disable iff (rst)
        irq_take |=> ##1 (mem_rd && mem_addr == $past(mem_rdata)));

    assert_ack_id_R12: assert property (@(posedge clk) disable iff (rst)
        irq_ack |-> (pend && ack_id == seen_id));

    assert_ack_resume_R12: assert property (@(posedge clk) disable iff (rst)
        irq_ack |=> mem_rd);

    assert_wb_not_read_R2: assert property (@(posedge clk) disable iff (rst)
        wb_we |-> !mem_rd);
endmodule

bind tiny16_core tiny16_core_chk #(.TBL_BASE(TBL_BASE), .IDW(IDW)) u_chk (.*);

// File: tb/test_tiny16_core.sv
module test_tiny16_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic [15:0] mem_rdata = '0;
    logic        irq_req = 1'b0;
    logic [15:0] irq_id = 16'd3;
    logic        irq_take, irq_ack, halted, wb_we;
    logic [15:0] ack_id, wb_data;
    logic [2:0]  wb_reg;

    tiny16_core #(.TBL_BASE(16'h0080), .IDW(16)) i_tiny16_core (
        .clk(clk), .rst(rst), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .irq_req(irq_req), .irq_id(irq_id),
        .irq_take(irq_take), .irq_ack(irq_ack), .ack_id(ack_id),
        .halted(halted), .wb_we(wb_we), .wb_reg(wb_reg), .wb_data(wb_data)
    );

    always #5 clk = ~clk;

    logic [15:0] mem [256];
    always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];

    int total = 0, bad = 0, cyc = 0, pg = 0, n_exp = 0, wb_cnt = 0;
    int takes = 0, acks = 0;
    bit allow_take = 0, done = 0;
    logic [15:0] mdl [8];
    logic [2:0]  exp_rd [256];
    logic [15:0] exp_v  [256];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [15:0] w);
        mem[pg] = w;
        pg++;
    endtask

    task automatic expect_wb(input logic [2:0] r, input logic [15:0] v);
        exp_rd[n_exp] = r;
        exp_v[n_exp]  = v;
        n_exp++;
        mdl[r] = v;
    endtask

    function automatic logic [15:0] smv(input bit neg, input logic [6:0] mag);
        return neg ? 16'(-int'(mag)) : 16'(mag);
    endfunction
    function automatic logic [15:0] e_addr(input logic [2:0] d, input logic [2:0] a, input logic [2:0] b);
        return {4'b0001, d, a, 1'b0, 2'b00, b};
    endfunction
    function automatic logic [15:0] e_addi(input logic [2:0] d, input logic [2:0] a, input bit n, input logic [3:0] m);
        return {4'b0001, d, a, 1'b1, n, m};
    endfunction
    function automatic logic [15:0] e_ld(input logic [2:0] d, input bit n, input logic [6:0] m);
        return {4'b0010, d, 1'b0, n, m};
    endfunction
    function automatic logic [15:0] e_mov(input logic [2:0] d, input logic [2:0] s);
        return {4'b0110, d, s, 6'b0};
    endfunction
    function automatic logic [15:0] e_rel(input logic [3:0] op, input logic [2:0] r, input int off);
        logic [8:0] o;
        o = 9'(off);
        return {op, r, o};
    endfunction

    // write-back and interrupt monitor (R2..R8, R10, R12)
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (wb_we) begin
                if (wb_cnt < n_exp) begin
                    chk(wb_reg == exp_rd[wb_cnt], $sformatf("R2-wb#%0d reg", wb_cnt), 32'(wb_reg), 32'(exp_rd[wb_cnt]));
                    chk(wb_data == exp_v[wb_cnt], $sformatf("R2 R3 R4 R5 wb#%0d data", wb_cnt), 32'(wb_data), 32'(exp_v[wb_cnt]));
                end else begin
                    chk(1'b0, "R8 unexpected write-back", 32'(wb_data), 32'hFFFF_FFFF);
                end
                wb_cnt++;
            end
            if (irq_take) begin
                takes++;
                chk(allow_take, "R10 take while running or halted", 32'(takes), 32'(0));
            end
            if (irq_ack) begin
                acks++;
                chk(ack_id == 16'd3, "R12 ack id", 32'(ack_id), 32'd3);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000 && !done) begin
            bad++;
            total++;
            $display("FAIL watchdog act=%0d exp=done", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    int getc_pre;
    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 256; i++) mem[i] = '0;
        for (int i = 0; i < 8; i++) mdl[i] = '0;
        // random arithmetic block
        for (int i = 0; i < 60; i++) begin
            logic [2:0] d, a, b;
            logic [6:0] m;
            bit n;
            int k;
            k = $urandom % 4;
            d = 3'($urandom); a = 3'($urandom); b = 3'($urandom);
            m = 7'($urandom); n = 1'($urandom);
            case (k)
                0: begin put(e_addr(d, a, b)); expect_wb(d, mdl[a] + mdl[b]); end
                1: begin put(e_addi(d, a, n, m[3:0])); expect_wb(d, mdl[a] + smv(n, {3'b0, m[3:0]})); end
                2: begin put(e_ld(d, n, m)); expect_wb(d, smv(n, m)); end
                default: begin put(e_mov(d, a)); expect_wb(d, mdl[a]); end
            endcase
        end
        // directed corners
        put(e_ld(3'd1, 1'b1, 7'd5));  expect_wb(3'd1, 16'hFFFB);  // R3 negative
        put(e_ld(3'd2, 1'b1, 7'd0));  expect_wb(3'd2, 16'h0000);  // R3 minus zero
        begin
            int data_at;
            data_at = pg;
            put(16'hE123);                                       // R8 data word
            put(16'h7ABC);                                       // R8 unused opcode
            put(16'hF005);                                       // R8 unknown trap
            put(e_ld(3'd3, 1'b0, 7'd9)); expect_wb(3'd3, 16'd9);
            put(e_rel(4'b0100, 3'd0, 1));                        // R6 jump
            put(e_ld(3'd4, 1'b0, 7'd1));
            put(e_ld(3'd4, 1'b0, 7'd2)); expect_wb(3'd4, 16'd2);
            put(e_rel(4'b0101, 3'd1, 1));                        // R7 taken
            put(e_ld(3'd5, 1'b0, 7'd1));
            put(e_ld(3'd5, 1'b0, 7'd3)); expect_wb(3'd5, 16'd3);
            put(e_rel(4'b0101, 3'd3, 1));                        // R7 not taken
            put(e_ld(3'd6, 1'b0, 7'd4)); expect_wb(3'd6, 16'd4);
            put(e_ld(3'd6, 1'b0, 7'd5)); expect_wb(3'd6, 16'd5);
            put(e_rel(4'b0011, 3'd7, data_at - (pg + 1)));       // R4 backward
            expect_wb(3'd7, 16'hE123);
        end
        put(e_mov(3'd5, 3'd7)); expect_wb(3'd5, 16'hE123);       // R5 move
        getc_pre = n_exp;
        put(16'hF001);                                           // R10 getc
        expect_wb(3'd0, 16'd7);                                  // handler load
        put(e_addr(3'd0, 3'd0, 3'd0)); expect_wb(3'd0, 16'd14);  // R12 resume
        put(16'hF000);                                           // R9 halt
        mem[8'h83] = 16'h00C0;                                   // R11 table entry
        mem[8'hC0] = e_rel(4'b0011, 3'd0, 16'h2F);
        mem[8'hC1] = 16'hF000;
        mem[8'hF0] = 16'd7;

        irq_req = 1'b1;                                          // R10 held while running
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #1;
        chk(mem_rd && mem_addr == 16'h0 && !halted && !wb_we, "R1 reset fetch", {15'b0, mem_rd, mem_addr}, 32'h0001_0000);
        wait (wb_cnt >= 60);
        @(negedge clk) irq_req = 1'b0;
        wait (wb_cnt >= getc_pre);
        repeat (20) @(negedge clk);
        chk(wb_cnt == getc_pre, "R10 parked no write-back", 32'(wb_cnt), 32'(getc_pre));
        chk(!halted, "R10 parked not halted", 32'(halted), 32'd0);
        chk(!mem_rd, "R10 parked no read", 32'(mem_rd), 32'd0);
        allow_take = 1'b1;
        irq_req = 1'b1;
        wait (takes == 1);
        @(negedge clk) irq_req = 1'b0;
        allow_take = 1'b0;
        wait (acks == 1);
        wait (halted);
        @(negedge clk);
        chk(wb_cnt == n_exp, "R11 R12 all results seen", 32'(wb_cnt), 32'(n_exp));
        chk(halted, "R9 halted", 32'(halted), 32'd1);
        irq_req = 1'b1;
        repeat (20) @(negedge clk);
        chk(takes == 1, "R9 no take when halted", 32'(takes), 32'd1);
        chk(halted && !mem_rd, "R9 stays halted", {31'b0, halted}, 32'd1);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule